// File: doc/BRIEF.md
# In-Order Completion Queue

This block tracks dispatched instructions in program order and retires them in that same order. Dispatch may place zero, one or two instructions into the queue in a cycle. Each instruction receives an entry index, which the execution units later use to report that the instruction has finished. Up to two finish reports arrive per cycle.

Retirement always starts from the oldest entry. In each cycle, the queue retires the oldest entry if it has finished. It also retires the next entry in the same cycle if that entry has finished too. For each retirement the queue presents the destination tag recorded at dispatch, so that write-back can take place. The entry becomes free at the end of that cycle.

A registered free-entry count lets dispatch stall before it overruns the queue. A synchronous flush discards everything in the queue.

Top module: `compq_top`

## Requirements
- R1: After reset, `free_cnt` equals DEPTH, `ret_vld` is 0, and the next allocation indices are 0 and 1.
- R2: An accepted request of `alloc_num` (0, 1 or 2) uses entry `alloc_idx0` for the first instruction and `alloc_idx1` for the second. `alloc_idx1` is `alloc_idx0`+1 modulo DEPTH. Successive allocations wrap from DEPTH-1 to 0.
- R3: A request with `alloc_num` greater than `free_cnt`, or equal to 3, is ignored entirely. No entry is taken and `free_cnt` does not change.
- R4: `free_cnt` always equals DEPTH minus the number of occupied entries, and it updates on the clock edge that ends the cycle of an allocation or a retirement.
- R5: A finished entry does not retire while any older entry is still present.
- R6: A finish report for the oldest entry makes `ret_vld[0]` high in the next cycle. At that point `ret_dst0` holds the tag given at dispatch.
- R7: When the two oldest entries have both finished, both retire in one cycle. `ret_vld` is then 2'b11, with the older entry's tag on `ret_dst0`. `ret_vld[1]` is never high without `ret_vld[0]`.
- R8: A retiring entry is presented for exactly one cycle and is free from the next cycle onward.
- R9: A finish report naming an unoccupied index has no effect.
- R10: `flush` empties the queue on the next edge and takes priority over an allocation in the same cycle. Afterwards the queue is in the R1 state.
- R11: Two finish reports in one cycle are both recorded.
- R12: When allocation and retirement fall in the same cycle, `free_cnt` changes by retired minus allocated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Synchronous queue clear |
| alloc_num | input | 2 | Number of instructions dispatched this cycle |
| alloc_dst0 | input | TAG_W | Destination tag of first dispatched instruction |
| alloc_dst1 | input | TAG_W | Destination tag of second dispatched instruction |
| alloc_idx0 | output | IDX_W | Entry index for the first instruction |
| alloc_idx1 | output | IDX_W | Entry index for the second instruction |
| free_cnt | output | CNT_W | Number of free entries |
| fin_vld | input | 2 | Finish report strobes |
| fin_idx0 | input | IDX_W | Entry index of finish report 0 |
| fin_idx1 | input | IDX_W | Entry index of finish report 1 |
| ret_vld | output | 2 | Retire strobes, bit 0 is the oldest |
| ret_dst0 | output | TAG_W | Tag for write-back of retire slot 0 |
| ret_dst1 | output | TAG_W | Tag for write-back of retire slot 1 |

## Verification
Allocation and retirement can occur in the same cycle, and both change the free count. To provoke this, the bench finishes the oldest entry and then presents a one-entry dispatch during the cycle in which that entry retires. It then checks that `free_cnt` has the net value on the next edge. The bench also sends two finish reports and a refused dispatch into a full queue in one cycle. This confirms that the double retirement appears and that the refusal holds the count at zero.

// File: rtl/compq_pkg.sv
package compq_pkg;
  // wrap an index sum back into 0..d-1 (sum never reaches 2*d)
  function automatic int wrap_idx(input int v, input int d);
    return (v >= d) ? v - d : v;
  endfunction
endpackage

// File: rtl/compq_ptr.sv
module compq_ptr #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic [1:0]       step,
  output logic [IDX_W-1:0] ptr,
  output logic [IDX_W-1:0] ptr_p1
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] ptr_p2;

  assign ptr    = ptr_q;
  assign ptr_p1 = IDX_W'(compq_pkg::wrap_idx(int'(ptr_q) + 1, DEPTH));
  assign ptr_p2 = IDX_W'(compq_pkg::wrap_idx(int'(ptr_q) + 2, DEPTH));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
    end else begin
      case (step)
        2'd1:    ptr_q <= ptr_p1;
        2'd2:    ptr_q <= ptr_p2;
        default: ptr_q <= ptr_q;
      endcase
    end
  end
endmodule

// File: rtl/compq_retsel.sv
module compq_retsel #(
  parameter int DEPTH = 6,
  parameter int IDX_W = 3
) (
  input  logic [DEPTH-1:0] vld,
  input  logic [DEPTH-1:0] done,
  input  logic [IDX_W-1:0] head,
  input  logic [IDX_W-1:0] head_p1,
  output logic [1:0]       ret,
  output logic [1:0]       ret_n
);
  always_comb begin
    ret[0] = vld[head] & done[head];
    ret[1] = ret[0] & vld[head_p1] & done[head_p1];
    ret_n  = {1'b0, ret[0]} + {1'b0, ret[1]};
  end
endmodule

// File: rtl/compq_top.sv
module compq_top #(
  parameter int DEPTH = 6,
  parameter int TAG_W = 6,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             flush,
  input  logic [1:0]       alloc_num,
  input  logic [TAG_W-1:0] alloc_dst0,
  input  logic [TAG_W-1:0] alloc_dst1,
  output logic [IDX_W-1:0] alloc_idx0,
  output logic [IDX_W-1:0] alloc_idx1,
  output logic [CNT_W-1:0] free_cnt,
  input  logic [1:0]       fin_vld,
  input  logic [IDX_W-1:0] fin_idx0,
  input  logic [IDX_W-1:0] fin_idx1,
  output logic [1:0]       ret_vld,
  output logic [TAG_W-1:0] ret_dst0,
  output logic [TAG_W-1:0] ret_dst1
);
  logic [DEPTH-1:0] vld_q, done_q;
  logic [TAG_W-1:0] dst_mem [DEPTH];
  logic [CNT_W-1:0] free_q;
  logic [IDX_W-1:0] tail, tail_p1, head, head_p1;
  logic [1:0]       acc_n, ret_n, ret;
  logic             acc_ok;

  // whole request accepted or refused against the registered free count
  assign acc_ok = (alloc_num != 2'd3) && (CNT_W'(alloc_num) <= free_q) && !flush;
  assign acc_n  = acc_ok ? alloc_num : 2'd0;

  compq_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) tail_i (
    .clk(clk), .rst(rst), .clr(flush), .step(acc_n),
    .ptr(tail), .ptr_p1(tail_p1)
  );

  compq_ptr #(.DEPTH(DEPTH), .IDX_W(IDX_W)) head_i (
    .clk(clk), .rst(rst), .clr(flush), .step(ret_n),
    .ptr(head), .ptr_p1(head_p1)
  );

  compq_retsel #(.DEPTH(DEPTH), .IDX_W(IDX_W)) sel_i (
    .vld(vld_q), .done(done_q), .head(head), .head_p1(head_p1),
    .ret(ret), .ret_n(ret_n)
  );

  assign alloc_idx0 = tail;
  assign alloc_idx1 = tail_p1;
  assign free_cnt   = free_q;
  assign ret_vld    = ret;
  assign ret_dst0   = dst_mem[head];
  assign ret_dst1   = dst_mem[head_p1];

  always_ff @(posedge clk) begin
    if (rst || flush) free_q <= CNT_W'(DEPTH);
    else              free_q <= free_q - CNT_W'(acc_n) + CNT_W'(ret_n);
  end

  // tag storage: write-only at dispatch, no reset
  always_ff @(posedge clk) begin
    if (acc_n != 2'd0) dst_mem[tail]    <= alloc_dst0;
    if (acc_n == 2'd2) dst_mem[tail_p1] <= alloc_dst1;
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic set_a, clr_r, fin_h;
    always_comb begin
      set_a = ((acc_n != 2'd0) && (tail == IDX_W'(i))) ||
              ((acc_n == 2'd2) && (tail_p1 == IDX_W'(i)));
      clr_r = (ret[0] && (head == IDX_W'(i))) ||
              (ret[1] && (head_p1 == IDX_W'(i)));
      fin_h = (fin_vld[0] && (fin_idx0 == IDX_W'(i))) ||
              (fin_vld[1] && (fin_idx1 == IDX_W'(i)));
    end
    always_ff @(posedge clk) begin
      if (rst || flush) begin
        vld_q[i]  <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (set_a) begin
        vld_q[i]  <= 1'b1;
        done_q[i] <= 1'b0;
      end else if (clr_r) begin
        vld_q[i]  <= 1'b0;
        done_q[i] <= 1'b0;
      end else if (fin_h && vld_q[i]) begin
        done_q[i] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/compq_chk.sv
module compq_chk #(
  parameter int DEPTH = 6,
  parameter int CNT_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             flush,
  input logic [1:0]       alloc_num,
  input logic [CNT_W-1:0] free_cnt,
  input logic [1:0]       ret_vld
);
  int acc_c, ret_c;
  always_comb begin
    acc_c = ((alloc_num != 2'd3) && (int'(alloc_num) <= int'(free_cnt))) ? int'(alloc_num) : 0;
    ret_c = int'(ret_vld[0]) + int'(ret_vld[1]);
  end

  assert_free_range_R4: assert property (@(posedge clk) disable iff (rst)
    int'(free_cnt) <= DEPTH);

  assert_ret_order_R7: assert property (@(posedge clk) disable iff (rst)
    ret_vld[1] |-> ret_vld[0]);

  assert_empty_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (int'(free_cnt) == DEPTH) |-> (ret_vld == 2'b00));

  assert_flush_clear_R10: assert property (@(posedge clk) disable iff (rst)
    flush |=> (int'(free_cnt) == DEPTH) && (ret_vld == 2'b00));

  assert_net_count_R12: assert property (@(posedge clk) disable iff (rst)
    !flush |=> int'(free_cnt) == int'($past(free_cnt)) - $past(acc_c) + $past(ret_c));
endmodule

bind compq_top compq_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .flush(flush), .alloc_num(alloc_num),
  .free_cnt(free_cnt), .ret_vld(ret_vld)
);

// File: tb/compq_top_tb_top.sv
module compq_top_tb_top;
  localparam int DEPTH = 6;
  localparam int TAG_W = 6;
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic flush = 1'b0;
  logic [1:0] alloc_num = '0;
  logic [TAG_W-1:0] alloc_dst0 = '0, alloc_dst1 = '0;
  logic [IDX_W-1:0] alloc_idx0, alloc_idx1;
  logic [CNT_W-1:0] free_cnt;
  logic [1:0] fin_vld = '0;
  logic [IDX_W-1:0] fin_idx0 = '0, fin_idx1 = '0;
  logic [1:0] ret_vld;
  logic [TAG_W-1:0] ret_dst0, ret_dst1;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;

  compq_top #(.DEPTH(DEPTH), .TAG_W(TAG_W)) dut_i (.*);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=5000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic idle();
    alloc_num = 0; fin_vld = 0; flush = 0;
  endtask

  task automatic alloc(input int n, input int d0, input int d1);
    alloc_num = 2'(n); alloc_dst0 = TAG_W'(d0); alloc_dst1 = TAG_W'(d1);
  endtask

  task automatic fin(input logic [1:0] v, input int i0, input int i1);
    fin_vld = v; fin_idx0 = IDX_W'(i0); fin_idx1 = IDX_W'(i1);
  endtask

  task automatic t_reset();
    rst = 1; idle(); tick(); tick(); rst = 0; tick();
    chk("R1 free", int'(free_cnt), DEPTH);
    chk("R1 ret", int'(ret_vld), 0);
    chk("R1 idx0", int'(alloc_idx0), 0);
    chk("R1 idx1", int'(alloc_idx1), 1);
  endtask

  task automatic t_inorder();
    alloc(2, 'h11, 'h12); tick(); idle();
    chk("R4 free after 2", int'(free_cnt), 4);
    chk("R2 idx0", int'(alloc_idx0), 2);
    alloc(1, 'h13, 0); tick(); idle();
    chk("R4 free after 3", int'(free_cnt), 3);
    fin(2'b01, 1, 0); tick(); idle();
    chk("R5 younger held", int'(ret_vld), 0);
    fin(2'b01, 0, 0); tick(); idle();
    chk("R7 pair", int'(ret_vld), 3);
    chk("R6 dst0", int'(ret_dst0), 'h11);
    chk("R7 dst1", int'(ret_dst1), 'h12);
    tick();
    chk("R8 one cycle", int'(ret_vld), 0);
    chk("R8 freed", int'(free_cnt), 5);
    fin(2'b01, 2, 0); tick(); idle();
    chk("R6 single", int'(ret_vld), 1);
    chk("R6 dst", int'(ret_dst0), 'h13);
    tick();
    chk("R4 empty", int'(free_cnt), 6);
  endtask

  task automatic t_wrap_full();
    alloc(2, 'h03, 'h04); tick();
    alloc(2, 'h05, 'h06);
    chk("R2 wrap idx0", int'(alloc_idx0), 5);
    chk("R2 wrap idx1", int'(alloc_idx1), 0);
    tick();
    alloc(2, 'h07, 'h08); tick();
    chk("R4 full", int'(free_cnt), 0);
    alloc(1, 'h3f, 0); tick();
    chk("R3 refused", int'(free_cnt), 0);
    alloc(3, 'h3f, 'h3f); tick();
    chk("R3 code3", int'(free_cnt), 0);
    alloc(1, 'h3f, 0); fin(2'b11, 3, 4); tick(); idle();
    chk("R11 both finished", int'(ret_vld), 3);
    chk("R11 dst0", int'(ret_dst0), 'h03);
    chk("R11 dst1", int'(ret_dst1), 'h04);
    tick();
    chk("R3 refused while full", int'(free_cnt), 2);
    fin(2'b01, 5, 0); tick(); idle();
    chk("R6 wrap head", int'(ret_dst0), 'h05);
    alloc(1, 'h09, 0);
    chk("R12 idx", int'(alloc_idx0), 3);
    tick(); idle();
    chk("R12 net", int'(free_cnt), 2);
    chk("R5 head not done", int'(ret_vld), 0);
  endtask

  task automatic t_flush();
    alloc(2, 'h3f, 'h3f); flush = 1; tick(); idle();
    chk("R10 free", int'(free_cnt), DEPTH);
    chk("R10 ret", int'(ret_vld), 0);
    chk("R10 idx0", int'(alloc_idx0), 0);
    fin(2'b01, 0, 0); tick(); idle();
    alloc(1, 'h21, 0); tick(); idle();
    chk("R9 stale finish", int'(ret_vld), 0);
    fin(2'b01, 3, 0); tick(); idle();
    chk("R9 empty index", int'(ret_vld), 0);
    chk("R9 free", int'(free_cnt), 5);
    fin(2'b01, 0, 0); tick(); idle();
    chk("R6 after flush", int'(ret_vld), 1);
    chk("R6 after flush dst", int'(ret_dst0), 'h21);
  endtask

  initial begin
    t_reset();
    t_inorder();
    t_wrap_full();
    t_flush();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule